// File: doc/BRIEF.md
# Prefetching DMA Read Buffer

This block sits between a slow peripheral bus, whose DMA master reads one 16-bit word at a time in block mode, and a fast system memory port that returns 32-bit longwords. It holds two quadword (four-word) buffers. A read that misses both buffers starts a demand fetch of its quadword. It also schedules a speculative fetch of the following quadword into the second buffer, on the expectation that the block transfer goes on. The peripheral gets its reply in the cycle after the longword holding the requested word arrives from memory. The block does not wait for the rest of the quadword.

When the master steps into the prefetched quadword, that buffer becomes the current one. The freed buffer is retargeted to the next sequential quadword and refilled in the background. Because memory runs several times faster than the peripheral bus, sequential block reads are normally answered from a buffer without stalling. DMA writes and explicit flushes name a word address through the invalidate port; any buffer holding that quadword is dropped. Memory errors make the buffer invalid and are reported on the waiting read.

Control is two state machines. The read controller has `RD_IDLE`, which accepts and classifies a request as a current hit, an other-buffer hit (swap) or a miss, and `RD_WAIT`, which holds a request until its longword lands. `RD_WAIT` returns to `RD_IDLE` on reply, on error reply, or on loss of the awaited buffer, in which case the held request is classified again. The fill engine has `FL_IDLE`, which picks a buffer needing data with the current buffer first, then `FL_ISSUE`, which holds the command until accepted, then `FL_BEAT0` and `FL_BEAT1`, which take the two longwords and return to `FL_IDLE`.

Top module: `dma_rd_prefetch`

## Requirements
- R1: After reset, rd_ack, rd_err and mem_cmd_valid are low and both buffers are empty, so the first read issues a memory command.
- R2: Word w (rd_addr[1:0]) of quadword q (rd_addr[WA_W-1:2]) comes from memory beat rd_addr[1]: half 0 is bits 15:0 and half 1 is bits 31:16. Beat 0 is delivered first. rd_data equals that memory word.
- R3: A read matching neither buffer issues a command for its own quadword q first and then one for q+1, wrapping modulo 2^(WA_W-2).
- R4: On a miss, rd_ack rises in the cycle after the beat carrying the requested longword is accepted. For words 0 and 1 this is before the second beat is delivered.
- R5: A read whose word is already held in a buffer is acknowledged one cycle after the request is first sampled, with no memory command.
- R6: A read hitting the non-current buffer makes it current and refetches the freed buffer as the next quadword. A sequential sweep over K quadwords from a miss issues exactly K+1 commands at consecutive quadword addresses.
- R7: A one-cycle inv_req whose address falls in a held quadword invalidates that buffer; the next read of that quadword is a miss.
- R8: An inv_req whose quadword is in neither buffer has no effect: later reads of held words still hit with no command.
- R9: A memory beat with mem_rsp_err leaves its buffer invalid. A read waiting on it is acknowledged with rd_err high. A read waiting on another buffer is not, and a later read of that quadword refetches it.
- R10: rd_ack is a one-cycle pulse given only while rd_req is held; rd_err is high only together with rd_ack.
- R11: mem_cmd_valid and mem_cmd_qaddr hold steady until mem_cmd_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Peripheral read request, held until rd_ack |
| rd_addr | input | WA_W | Word address of the read |
| rd_ack | output | 1 | One-cycle reply strobe |
| rd_data | output | 16 | Read word, valid with rd_ack |
| rd_err | output | 1 | Read failed, valid with rd_ack |
| inv_req | input | 1 | Invalidate strobe for a DMA write or flush |
| inv_addr | input | WA_W | Word address to invalidate |
| mem_cmd_valid | output | 1 | Quadword fetch command valid |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_qaddr | output | WA_W-2 | Quadword address to fetch |
| mem_rsp_valid | input | 1 | Longword beat valid |
| mem_rsp_data | input | 32 | Longword beat data |
| mem_rsp_err | input | 1 | Beat carries an error |

## Verification
A wrong tag or valid bit shows within one read as a stale rd_data word or as a missing or extra memory command. For this reason the memory model logs every quadword address and the bench compares command counts and order after each access. A fault in the swap or prefetch pointer appears at the next quadword boundary of a sequential sweep, as a one-cycle hit turning into a multi-cycle miss. A bypass or beat-index fault appears on the first miss as data from the wrong half or longword, or as an ack that arrives one beat late. The bench sweeps every word offset on misses and checks the count of delivered beats at the moment of the ack.

// File: rtl/dma_rd_prefetch_pkg.sv
package dma_rd_prefetch_pkg;

    localparam int WORD_W  = 16;
    localparam int LWORD_W = 32;
    localparam int QWORD_W = 64;
    localparam int NSLOT   = 2;

    typedef enum logic [0:0] {
        RD_IDLE,
        RD_WAIT
    } rd_state_t;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_ISSUE,
        FL_BEAT0,
        FL_BEAT1
    } fl_state_t;

endpackage

// File: rtl/dma_rd_prefetch_slot.sv
module dma_rd_prefetch_slot
    import dma_rd_prefetch_pkg::*;
#(
    parameter int QA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [QA_W-1:0]   alloc_tag,
    input  logic              take,
    input  logic              snoop_v,
    input  logic [QA_W-1:0]   snoop_tag,
    input  logic              wr_v,
    input  logic              wr_idx,
    input  logic [LWORD_W-1:0] wr_data,
    input  logic              err_v,
    output logic              vld,
    output logic              pend,
    output logic [QA_W-1:0]   tag,
    output logic [1:0]        lv,
    output logic [QWORD_W-1:0] data,
    output logic              touch
);

    logic snoop_hit;

    assign snoop_hit = snoop_v && vld && (snoop_tag == tag);
    assign touch     = alloc || snoop_hit || err_v;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            pend <= 1'b0;
            tag  <= '0;
            lv   <= '0;
            data <= '0;
        end else if (alloc) begin
            vld  <= 1'b1;
            pend <= 1'b1;
            tag  <= alloc_tag;
            lv   <= '0;
        end else if (snoop_hit || err_v) begin
            vld  <= 1'b0;
            pend <= 1'b0;
            lv   <= '0;
        end else begin
            if (take) begin
                pend <= 1'b0;
            end
            if (wr_v) begin
                lv[wr_idx] <= 1'b1;
                if (wr_idx) begin
                    data[QWORD_W-1:LWORD_W] <= wr_data;
                end else begin
                    data[LWORD_W-1:0] <= wr_data;
                end
            end
        end
    end

    AST_LV_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lv != 2'b00) |-> vld); // R7

    AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit && !alloc) |=> (!vld && lv == 2'b00)); // R7

    AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_v && !alloc) |=> !vld); // R9

endmodule

// File: rtl/dma_rd_prefetch_fill.sv
module dma_rd_prefetch_fill
    import dma_rd_prefetch_pkg::*;
#(
    parameter int QA_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cur,
    input  logic [NSLOT-1:0]           pend,
    input  logic [NSLOT-1:0][QA_W-1:0] tag,
    input  logic [NSLOT-1:0]           touch,
    output logic [NSLOT-1:0]           take,
    output logic                       mem_cmd_valid,
    input  logic                       mem_cmd_ready,
    output logic [QA_W-1:0]            mem_cmd_qaddr,
    input  logic                       mem_rsp_valid,
    input  logic [LWORD_W-1:0]         mem_rsp_data,
    input  logic                       mem_rsp_err,
    output logic                       beat_v,
    output logic                       beat_err,
    output logic                       beat_idx,
    output logic                       beat_buf,
    output logic [LWORD_W-1:0]         beat_data
);

    fl_state_t       fs, fs_n;
    logic            fbuf;
    logic            kill;
    logic [QA_W-1:0] qaddr;
    logic            pick;
    logic            start;
    logic            in_beat;

    always_comb begin
        start = 1'b0;
        pick  = cur;
        take  = '0;
        if (fs == FL_IDLE) begin
            if (pend[cur]) begin
                start = 1'b1;
                pick  = cur;
            end else if (pend[~cur]) begin
                start = 1'b1;
                pick  = ~cur;
            end
        end
        if (start) begin
            take[pick] = 1'b1;
        end
    end

    always_comb begin
        fs_n = fs;
        unique case (fs)
            FL_IDLE:  if (start)         fs_n = FL_ISSUE;
            FL_ISSUE: if (mem_cmd_ready) fs_n = FL_BEAT0;
            FL_BEAT0: if (mem_rsp_valid) fs_n = FL_BEAT1;
            FL_BEAT1: if (mem_rsp_valid) fs_n = FL_IDLE;
            default:                     fs_n = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs <= FL_IDLE;
        end else begin
            fs <= fs_n;
        end
    end

    assign in_beat = (fs == FL_BEAT0) || (fs == FL_BEAT1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fbuf  <= 1'b0;
            kill  <= 1'b0;
            qaddr <= '0;
        end else if (start) begin
            fbuf  <= pick;
            kill  <= touch[pick];
            qaddr <= tag[pick];
        end else if (fs != FL_IDLE) begin
            kill <= kill || touch[fbuf] || (in_beat && mem_rsp_valid && mem_rsp_err);
        end
    end

    assign mem_cmd_valid = (fs == FL_ISSUE);
    assign mem_cmd_qaddr = qaddr;
    assign beat_v        = in_beat && mem_rsp_valid && !mem_rsp_err && !kill;
    assign beat_err      = in_beat && mem_rsp_valid && mem_rsp_err && !kill;
    assign beat_idx      = (fs == FL_BEAT1);
    assign beat_buf      = fbuf;
    assign beat_data     = mem_rsp_data;

    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_cmd_ready) |=> (mem_cmd_valid && $stable(mem_cmd_qaddr))); // R11

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take)); // R6

    AST_NO_BEAT_AND_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_v && beat_err)); // R9

endmodule

// File: rtl/dma_rd_prefetch_ctl.sv
module dma_rd_prefetch_ctl
    import dma_rd_prefetch_pkg::*;
#(
    parameter int WA_W = 12,
    parameter int QA_W = WA_W - 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_req,
    input  logic [WA_W-1:0]               rd_addr,
    input  logic [NSLOT-1:0]              vld,
    input  logic [NSLOT-1:0][1:0]         lv,
    input  logic [NSLOT-1:0][QA_W-1:0]    tag,
    input  logic [NSLOT-1:0][QWORD_W-1:0] sdata,
    input  logic                          beat_v,
    input  logic                          beat_err,
    input  logic                          beat_idx,
    input  logic                          beat_buf,
    input  logic [LWORD_W-1:0]            beat_data,
    output logic                          cur,
    output logic [NSLOT-1:0]              alloc,
    output logic [NSLOT-1:0][QA_W-1:0]    alloc_tag,
    output logic                          rd_ack,
    output logic [WORD_W-1:0]             rd_data,
    output logic                          rd_err
);

    localparam logic [QA_W-1:0] Q_ONE = QA_W'(1);

    rd_state_t          cs, cs_n;
    logic               cur_n;
    logic               wbuf, wbuf_n;
    logic [QA_W-1:0]    rtag;
    logic               rlw, rhf;
    logic               oth;
    logic               hit_c, hit_o, sel;
    logic               ack_n, err_n;
    logic [WORD_W-1:0]  data_n;

    function automatic logic [WORD_W-1:0] word_of(input logic [QWORD_W-1:0] q,
                                                  input logic lw, input logic hf);
        return q[{lw, hf}*WORD_W +: WORD_W];
    endfunction

    assign rtag  = rd_addr[WA_W-1:2];
    assign rlw   = rd_addr[1];
    assign rhf   = rd_addr[0];
    assign oth   = ~cur;
    assign hit_c = vld[cur] && (tag[cur] == rtag);
    assign hit_o = vld[oth] && (tag[oth] == rtag);

    always_comb begin
        cs_n      = cs;
        cur_n     = cur;
        wbuf_n    = wbuf;
        alloc     = '0;
        alloc_tag = '0;
        ack_n     = 1'b0;
        err_n     = 1'b0;
        data_n    = '0;
        sel       = cur;
        unique case (cs)
            RD_IDLE: begin
                if (rd_req && !rd_ack) begin
                    if (hit_c) begin
                        sel = cur;
                    end else if (hit_o) begin
                        sel             = oth;
                        cur_n           = oth;
                        alloc[cur]      = 1'b1;
                        alloc_tag[cur]  = rtag + Q_ONE;
                    end else begin
                        sel             = cur;
                        alloc[cur]      = 1'b1;
                        alloc_tag[cur]  = rtag;
                        alloc[oth]      = 1'b1;
                        alloc_tag[oth]  = rtag + Q_ONE;
                    end
                    if ((hit_c || hit_o) && lv[sel][rlw]) begin
                        ack_n  = 1'b1;
                        data_n = word_of(sdata[sel], rlw, rhf);
                    end else begin
                        cs_n   = RD_WAIT;
                        wbuf_n = sel;
                    end
                end
            end
            RD_WAIT: begin
                if (beat_err && beat_buf == wbuf) begin
                    ack_n = 1'b1;
                    err_n = 1'b1;
                    cs_n  = RD_IDLE;
                end else if (beat_v && beat_buf == wbuf && beat_idx == rlw) begin
                    ack_n  = 1'b1;
                    data_n = rhf ? beat_data[LWORD_W-1:WORD_W] : beat_data[WORD_W-1:0];
                    cs_n   = RD_IDLE;
                end else if (vld[wbuf] && lv[wbuf][rlw]) begin
                    ack_n  = 1'b1;
                    data_n = word_of(sdata[wbuf], rlw, rhf);
                    cs_n   = RD_IDLE;
                end else if (!vld[wbuf]) begin
                    cs_n = RD_IDLE;
                end
            end
            default: cs_n = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs   <= RD_IDLE;
            cur  <= 1'b0;
            wbuf <= 1'b0;
        end else begin
            cs   <= cs_n;
            cur  <= cur_n;
            wbuf <= wbuf_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ack  <= 1'b0;
            rd_err  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_ack  <= ack_n;
            rd_err  <= err_n;
            rd_data <= data_n;
        end
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack); // R10

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ack) |-> $past(rd_req)); // R10

    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_ack); // R9

    AST_TAGS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[0] && vld[1]) |-> (tag[0] != tag[1])); // R6

endmodule

// File: rtl/dma_rd_prefetch.sv
module dma_rd_prefetch
    import dma_rd_prefetch_pkg::*;
#(
    parameter int WA_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic [WA_W-1:0]     rd_addr,
    output logic                rd_ack,
    output logic [WORD_W-1:0]   rd_data,
    output logic                rd_err,
    input  logic                inv_req,
    input  logic [WA_W-1:0]     inv_addr,
    output logic                mem_cmd_valid,
    input  logic                mem_cmd_ready,
    output logic [WA_W-3:0]     mem_cmd_qaddr,
    input  logic                mem_rsp_valid,
    input  logic [LWORD_W-1:0]  mem_rsp_data,
    input  logic                mem_rsp_err
);

    localparam int QA_W = WA_W - 2;

    logic [NSLOT-1:0]              vld, pend, touch, take, alloc;
    logic [NSLOT-1:0][1:0]         lv;
    logic [NSLOT-1:0][QA_W-1:0]    tag, alloc_tag;
    logic [NSLOT-1:0][QWORD_W-1:0] sdata;
    logic                          cur;
    logic                          beat_v, beat_err, beat_idx, beat_buf;
    logic [LWORD_W-1:0]            beat_data;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        dma_rd_prefetch_slot #(.QA_W(QA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc[i]),
            .alloc_tag (alloc_tag[i]),
            .take      (take[i]),
            .snoop_v   (inv_req),
            .snoop_tag (inv_addr[WA_W-1:2]),
            .wr_v      (beat_v && (beat_buf == 1'(i))),
            .wr_idx    (beat_idx),
            .wr_data   (beat_data),
            .err_v     (beat_err && (beat_buf == 1'(i))),
            .vld       (vld[i]),
            .pend      (pend[i]),
            .tag       (tag[i]),
            .lv        (lv[i]),
            .data      (sdata[i]),
            .touch     (touch[i])
        );
    end

    dma_rd_prefetch_fill #(.QA_W(QA_W)) u_fill (
        .clk           (clk),
        .rst_n         (rst_n),
        .cur           (cur),
        .pend          (pend),
        .tag           (tag),
        .touch         (touch),
        .take          (take),
        .mem_cmd_valid (mem_cmd_valid),
        .mem_cmd_ready (mem_cmd_ready),
        .mem_cmd_qaddr (mem_cmd_qaddr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .beat_v        (beat_v),
        .beat_err      (beat_err),
        .beat_idx      (beat_idx),
        .beat_buf      (beat_buf),
        .beat_data     (beat_data)
    );

    dma_rd_prefetch_ctl #(.WA_W(WA_W), .QA_W(QA_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .vld       (vld),
        .lv        (lv),
        .tag       (tag),
        .sdata     (sdata),
        .beat_v    (beat_v),
        .beat_err  (beat_err),
        .beat_idx  (beat_idx),
        .beat_buf  (beat_buf),
        .beat_data (beat_data),
        .cur       (cur),
        .alloc     (alloc),
        .alloc_tag (alloc_tag),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .rd_err    (rd_err)
    );

endmodule

// File: tb/dma_rd_prefetch_test.sv
module dma_rd_prefetch_test;

    localparam int WA_W = 12;
    localparam int QA_W = WA_W - 2;
    localparam int LAT  = 3;
    localparam int GAP  = 3;
    localparam int QUIET = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0;
    logic [WA_W-1:0]   rd_addr = '0;
    logic              rd_ack, rd_err;
    logic [15:0]       rd_data;
    logic              inv_req = 1'b0;
    logic [WA_W-1:0]   inv_addr = '0;
    logic              mem_cmd_valid;
    logic              mem_cmd_ready = 1'b0;
    logic [QA_W-1:0]   mem_cmd_qaddr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic              mem_rsp_err = 1'b0;

    int tests = 0;
    int fails = 0;
    int cmd_cnt = 0;
    int cmd_log [0:127];
    int fill_beats = 0;
    int err_q = -1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dma_rd_prefetch #(.WA_W(WA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
        .inv_req(inv_req), .inv_addr(inv_addr),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_qaddr(mem_cmd_qaddr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
    );

    function automatic logic [15:0] mword(input int a);
        return 16'(a * 40503 + 4660);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory model: stalls the command, then two beats with a gap
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_cmd_valid) begin
                int qa;
                qa = int'(mem_cmd_qaddr);
                repeat (2) @(negedge clk);
                chk(mem_cmd_valid && int'(mem_cmd_qaddr) == qa, "R11 cmd held", int'(mem_cmd_qaddr), qa);
                mem_cmd_ready = 1'b1;
                if (cmd_cnt < 128) cmd_log[cmd_cnt] = qa;
                cmd_cnt++;
                @(negedge clk);
                mem_cmd_ready = 1'b0;
                fill_beats = 0;
                repeat (LAT) @(negedge clk);
                for (int b = 0; b < 2; b++) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_err   = (qa == err_q);
                    mem_rsp_data  = {mword(qa*4 + b*2 + 1), mword(qa*4 + b*2)};
                    fill_beats    = b + 1;
                    @(negedge clk);
                    mem_rsp_valid = 1'b0;
                    mem_rsp_err   = 1'b0;
                    if (b == 0) repeat (GAP) @(negedge clk);
                end
            end
        end
    end

    task automatic rd(input int a, output logic [15:0] dat, output logic er,
                      output int lat, output int bts);
        @(negedge clk);
        rd_req  = 1'b1;
        rd_addr = WA_W'(a);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rd_ack && lat < 500);
        dat = rd_data;
        er  = rd_err;
        bts = fill_beats;
        rd_req = 1'b0;
        @(negedge clk);
        chk(!rd_ack, "R10 ack pulse", int'(rd_ack), 0);
    endtask

    task automatic inv(input int a);
        @(negedge clk);
        inv_req  = 1'b1;
        inv_addr = WA_W'(a);
        @(negedge clk);
        inv_req  = 1'b0;
    endtask

    task automatic quiet();
        repeat (QUIET) @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        logic e;
        int lat, bts, c0, q;

        repeat (4) @(negedge clk);
        chk(!rd_ack && !rd_err, "R1 reset ack", int'(rd_ack), 0);
        chk(!mem_cmd_valid, "R1 reset cmd", int'(mem_cmd_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cmd_cnt == 0 && !mem_cmd_valid, "R1 idle after reset", cmd_cnt, 0);

        // misses at every word offset: data, early reply, command order
        for (int w = 0; w < 4; w++) begin
            q  = 100 + 8 * w;
            c0 = cmd_cnt;
            rd(q*4 + w, d, e, lat, bts);
            chk(d == mword(q*4 + w), "R2 miss data", int'(d), int'(mword(q*4 + w)));
            chk(!e, "R9 no err", int'(e), 0);
            chk(bts == (w / 2) + 1, "R4 early reply beats", bts, (w / 2) + 1);
            quiet();
            chk(cmd_cnt == c0 + 2, "R3 two commands", cmd_cnt - c0, 2);
            chk(cmd_log[c0] == q, "R3 demand first", cmd_log[c0], q);
            chk(cmd_log[c0 + 1] == q + 1, "R3 prefetch next", cmd_log[c0 + 1], q + 1);
            if (w == 0) chk(c0 == 0, "R1 first read misses", c0, 0);
        end

        // sequential sweep over six quadwords
        c0 = cmd_cnt;
        for (int i = 0; i < 24; i++) begin
            rd(300*4 + i, d, e, lat, bts);
            chk(d == mword(300*4 + i), "R2 sweep data", int'(d), int'(mword(300*4 + i)));
            if (i > 0) chk(lat == 1, "R5 R6 sweep hit latency", lat, 1);
            quiet();
        end
        chk(cmd_cnt == c0 + 7, "R6 sweep command count", cmd_cnt - c0, 7);
        for (int k = 0; k < 7; k++) begin
            chk(cmd_log[c0 + k] == 300 + k, "R6 sweep order", cmd_log[c0 + k], 300 + k);
        end

        // invalidate a quadword held nowhere
        inv(50*4 + 2);
        quiet();
        c0 = cmd_cnt;
        rd(305*4 + 3, d, e, lat, bts);
        chk(lat == 1 && cmd_cnt == c0, "R8 unrelated inv no effect", lat, 1);
        chk(d == mword(305*4 + 3), "R8 data kept", int'(d), int'(mword(305*4 + 3)));
        rd(306*4 + 0, d, e, lat, bts);
        chk(lat == 1 && d == mword(306*4), "R8 prefetched kept", lat, 1);

        // invalidate the current buffer
        inv(306*4 + 1);
        quiet();
        c0 = cmd_cnt;
        rd(306*4 + 2, d, e, lat, bts);
        chk(lat > 1, "R7 current inv forces miss", lat, 2);
        chk(d == mword(306*4 + 2), "R7 refetched data", int'(d), int'(mword(306*4 + 2)));
        quiet();
        chk(cmd_cnt == c0 + 2 && cmd_log[c0] == 306, "R7 refetch command", cmd_log[c0], 306);

        // invalidate the prefetched buffer
        inv(307*4 + 3);
        quiet();
        c0 = cmd_cnt;
        rd(307*4, d, e, lat, bts);
        chk(lat > 1 && cmd_log[c0] == 307, "R7 prefetched inv forces miss", cmd_log[c0], 307);
        chk(d == mword(307*4), "R7 data after inv", int'(d), int'(mword(307*4)));
        quiet();

        // wrap of the prefetch address
        c0 = cmd_cnt;
        rd(1023*4 + 1, d, e, lat, bts);
        chk(d == mword(1023*4 + 1), "R2 top data", int'(d), int'(mword(1023*4 + 1)));
        quiet();
        chk(cmd_log[c0] == 1023 && cmd_log[c0 + 1] == 0, "R3 wrap prefetch", cmd_log[c0 + 1], 0);
        rd(0, d, e, lat, bts);
        chk(lat == 1 && d == mword(0), "R6 swap into wrapped", lat, 1);
        quiet();

        // demand error
        err_q = 500;
        rd(500*4 + 3, d, e, lat, bts);
        chk(e == 1'b1, "R9 demand error flagged", int'(e), 1);
        quiet();
        err_q = -1;
        c0 = cmd_cnt;
        rd(500*4 + 3, d, e, lat, bts);
        chk(!e && d == mword(500*4 + 3), "R9 retry data", int'(d), int'(mword(500*4 + 3)));
        chk(cmd_cnt > c0 && cmd_log[c0] == 500, "R9 retry refetches", cmd_log[c0], 500);
        quiet();

        // prefetch error: silent, later read refetches
        err_q = 601;
        rd(600*4, d, e, lat, bts);
        chk(!e && d == mword(600*4), "R9 demand ok beside bad prefetch", int'(e), 0);
        quiet();
        err_q = -1;
        c0 = cmd_cnt;
        rd(601*4 + 1, d, e, lat, bts);
        chk(!e && d == mword(601*4 + 1), "R9 after prefetch error data", int'(d), int'(mword(601*4 + 1)));
        chk(cmd_cnt > c0 && cmd_log[c0] == 601, "R9 prefetch error refetch", cmd_log[c0], 601);
        quiet();

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule